// File: doc/BRIEF.md
# Seconds Counter Real-Time Clock

This peripheral keeps time as a single 32-bit count of seconds. A prescaler divides the bus clock by a parameter to make a one-cycle tick once per second. On each tick, an enabled counter either advances by one, takes a value that software staged earlier, or returns to zero after an alarm match. Software reaches the block through a plain word-addressed read/write port. A single interrupt line signals the alarm.

Software loads a new time by writing the staging register. That value reaches the counter only at the next tick, so the count never changes between ticks. An alarm compare value sets a raw event flag when the count equals it at a tick. Two control bits, an enable and a mask, gate the raw flag onto the interrupt pin. Software clears the event as a side effect of reading the acknowledge register.

Top module: `sec_rtc`

## Requirements
- R1: After reset, the count, compare, staging and control registers all read 0, both status words read 0, and `irq_o` is 0.
- R2: Byte offsets are 0x00 count, 0x04 compare, 0x08 staging, 0x0C control, 0x10 gated status, 0x14 raw status, 0x18 acknowledge and 0x1C version. The version word returns the `VERSION` parameter and ignores writes.
- R3: The tick occurs once every `DIV` clocks. With control bit 2 (run) at 1, each tick adds one to the count. With run at 0, the count holds.
- R4: The staging register reads back the last value written. Its value enters the count at the first tick with run=1 after the write, and not before. A write in the same cycle as a tick is applied at the following tick.
- R5: Raw status bit 0 sets at a tick with run=1 when the count equals the compare value. This happens whatever control bits 0 and 1 hold.
- R6: `irq_o` and gated status bit 0 are 1 exactly when raw status is 1, control bit 0 (enable) is 1 and control bit 1 (mask) is 0.
- R7: A read of the acknowledge offset clears raw status. If that read falls in the same cycle as a matching tick, raw status stays 1.
- R8: With control bit 3 (wrap) at 1, a matching tick sends the count to 0. With wrap at 0, the count steps from all-ones to 0.
- R9: Writes to the count, status and acknowledge offsets have no effect. Control keeps only bits 3:0 of a write.
- R10: A staged value pending at a tick wins over both increment and wrap. The match check at that tick still uses the count held before the tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock, also the prescaler source |
| rst_ni | input | 1 | Active-low synchronous reset |
| wr_en_i | input | 1 | Write strobe for `addr_i`/`wdata_i` |
| rd_en_i | input | 1 | Read strobe; a read at offset 0x18 acknowledges |
| addr_i | input | ADDR_W | Byte offset of the access |
| wdata_i | input | DATA_W | Write data |
| rdata_o | output | DATA_W | Combinational read data for `addr_i` |
| irq_o | output | 1 | Gated alarm interrupt |

## Verification
An acknowledge read and a matching tick can land in the same clock cycle, and the design must resolve the conflict toward keeping the event. The bench finds the tick phase from the first count change after a tick. It then counts `DIV` cycles forward and places the acknowledge strobe exactly on the next matching tick edge. Afterwards it expects raw status still at 1 and the count one past the compare value. A second collision places a staging write just before a matching tick with wrap on: the bench expects the staged value in the counter and the event recorded.

// File: rtl/sec_rtc_pkg.sv
package sec_rtc_pkg;

   // byte offsets of the register words
   localparam int unsigned OFF_COUNT = 'h00;
   localparam int unsigned OFF_MATCH = 'h04;
   localparam int unsigned OFF_LOAD  = 'h08;
   localparam int unsigned OFF_CTRL  = 'h0C;
   localparam int unsigned OFF_STAT  = 'h10;
   localparam int unsigned OFF_RAW   = 'h14;
   localparam int unsigned OFF_ACK   = 'h18;
   localparam int unsigned OFF_VER   = 'h1C;

   localparam int unsigned CTRL_W = 4;

   // member order fixes the bit positions: ie is bit 0, wrap is bit 3
   typedef struct packed {
      logic wrap;
      logic run;
      logic mask;
      logic ie;
   } ctrl_t;

endpackage

// File: rtl/sec_rtc_prescaler.sv
module sec_rtc_prescaler #(
   parameter int unsigned DIV = 50_000_000
) (
   input  logic clk_i,
   input  logic rst_ni,
   output logic tick_o
);

   if (DIV < 1) begin : g_bad_div
      $error("sec_rtc_prescaler: DIV must be at least 1");
   end

   if (DIV == 1) begin : g_pass
      assign tick_o = 1'b1;
   end else begin : g_div
      localparam int unsigned PW = $clog2(DIV);
      localparam logic [PW-1:0] LAST = PW'(DIV - 1);

      logic [PW-1:0] pre_q;

      always_ff @(posedge clk_i) begin
         if (!rst_ni)              pre_q <= '0;
         else if (pre_q == LAST)   pre_q <= '0;
         else                      pre_q <= pre_q + 1'b1;
      end

      assign tick_o = (pre_q == LAST);

      // R3: no two ticks back to back when dividing
      a_r3_tick_spacing: assert property (@(posedge clk_i) disable iff (!rst_ni)
         tick_o |=> !tick_o);
   end

endmodule

// File: rtl/sec_rtc_core.sv
module sec_rtc_core #(
   parameter int unsigned DATA_W = 32
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              tick_i,
   input  logic              run_i,
   input  logic              wrap_i,
   input  logic [DATA_W-1:0] match_i,
   input  logic [DATA_W-1:0] stage_i,
   input  logic              stage_wr_i,
   input  logic              ack_i,
   output logic [DATA_W-1:0] count_o,
   output logic              raw_o
);

   logic [DATA_W-1:0] cnt_q;
   logic              pend_q;
   logic              raw_q;
   logic              step;
   logic              hit;
   logic              event_set;

   assign step      = tick_i && run_i;
   assign hit       = (cnt_q == match_i);
   assign event_set = step && hit;

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         cnt_q  <= '0;
         pend_q <= 1'b0;
         raw_q  <= 1'b0;
      end else begin
         if (step) begin
            if (pend_q)            cnt_q <= stage_i;
            else if (wrap_i && hit) cnt_q <= '0;
            else                   cnt_q <= cnt_q + 1'b1;
         end
         if (stage_wr_i)  pend_q <= 1'b1;
         else if (step)   pend_q <= 1'b0;
         if (event_set)   raw_q <= 1'b1;
         else if (ack_i)  raw_q <= 1'b0;
      end
   end

   assign count_o = cnt_q;
   assign raw_o   = raw_q;

   // R3: the count moves only on an enabled tick
   a_r3_hold_between: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !step |=> cnt_q == $past(cnt_q));

   // R3: a plain enabled tick adds exactly one
   a_r3_step_by_one: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (step && !pend_q && !(wrap_i && hit)) |=> cnt_q == $past(cnt_q) + 1'b1);

   // R4: a pending staged value lands on the tick
   a_r4_stage_lands: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (step && pend_q) |=> cnt_q == $past(stage_i));

   // R5: raw status rises only after an enabled tick
   a_r5_raw_after_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(raw_q) |-> $past(tick_i && run_i));

   // R7: acknowledge clears unless a new match collides
   a_r7_ack_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ack_i && !event_set) |=> !raw_q);

endmodule

// File: rtl/sec_rtc.sv
module sec_rtc #(
   parameter int unsigned      DATA_W  = 32,
   parameter int unsigned      ADDR_W  = 5,
   parameter int unsigned      DIV     = 50_000_000,
   parameter logic [DATA_W-1:0] VERSION = DATA_W'('h0001_0200)
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              wr_en_i,
   input  logic              rd_en_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [DATA_W-1:0] wdata_i,
   output logic [DATA_W-1:0] rdata_o,
   output logic              irq_o
);
   import sec_rtc_pkg::*;

   if (DATA_W < CTRL_W) begin : g_bad_data_w
      $error("sec_rtc: DATA_W too small for control word");
   end
   if (ADDR_W < 5) begin : g_bad_addr_w
      $error("sec_rtc: ADDR_W must reach offset 0x1C");
   end

   logic [DATA_W-1:0] match_q;
   logic [DATA_W-1:0] stage_q;
   ctrl_t             ctrl_q;
   logic              tick;
   logic              raw;
   logic              gated;
   logic [DATA_W-1:0] count;
   logic              wr_match, wr_stage, wr_ctrl, ack;

   assign wr_match = wr_en_i && (addr_i == ADDR_W'(OFF_MATCH));
   assign wr_stage = wr_en_i && (addr_i == ADDR_W'(OFF_LOAD));
   assign wr_ctrl  = wr_en_i && (addr_i == ADDR_W'(OFF_CTRL));
   assign ack      = rd_en_i && (addr_i == ADDR_W'(OFF_ACK));

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         match_q <= '0;
         stage_q <= '0;
         ctrl_q  <= '0;
      end else begin
         if (wr_match) match_q <= wdata_i;
         if (wr_stage) stage_q <= wdata_i;
         if (wr_ctrl)  ctrl_q  <= ctrl_t'(wdata_i[CTRL_W-1:0]);
      end
   end

   sec_rtc_prescaler #(.DIV(DIV)) u_pre (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .tick_o (tick)
   );

   sec_rtc_core #(.DATA_W(DATA_W)) u_core (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .tick_i     (tick),
      .run_i      (ctrl_q.run),
      .wrap_i     (ctrl_q.wrap),
      .match_i    (match_q),
      .stage_i    (stage_q),
      .stage_wr_i (wr_stage),
      .ack_i      (ack),
      .count_o    (count),
      .raw_o      (raw)
   );

   assign gated = raw && ctrl_q.ie && !ctrl_q.mask;
   assign irq_o = gated;

   always_comb begin
      rdata_o = '0;
      case (addr_i)
         ADDR_W'(OFF_COUNT): rdata_o = count;
         ADDR_W'(OFF_MATCH): rdata_o = match_q;
         ADDR_W'(OFF_LOAD):  rdata_o = stage_q;
         ADDR_W'(OFF_CTRL):  rdata_o = DATA_W'(ctrl_q);
         ADDR_W'(OFF_STAT):  rdata_o = DATA_W'(gated);
         ADDR_W'(OFF_RAW):   rdata_o = DATA_W'(raw);
         ADDR_W'(OFF_VER):   rdata_o = VERSION;
         default:            rdata_o = '0;
      endcase
   end

   // R6: no interrupt while the mask bit is set
   a_r6_mask_blocks: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ctrl_q.mask |-> !irq_o);

   // R9: the control word never holds bits above bit 3
   a_r9_ctrl_width: assert property (@(posedge clk_i) disable iff (!rst_ni)
      wr_ctrl |=> ctrl_q == ctrl_t'($past(wdata_i[CTRL_W-1:0])));

endmodule

// File: tb/sec_rtc_tb_top.sv
`timescale 1ns/1ps
module sec_rtc_tb_top;

   localparam int unsigned DIV = 10;
   localparam logic [31:0] VER = 32'h00A5_0102;

   typedef struct packed {
      logic [4:0]  a;
      logic [31:0] w;
      logic [31:0] e;
   } vec_t;

   // write, then read back: offset, data written, value expected
   localparam vec_t VECS [0:6] = '{
      '{5'h00, 32'hDEAD_BEEF, 32'h0000_0000},   // R9 count read-only
      '{5'h04, 32'h1234_5678, 32'h1234_5678},   // R2 compare
      '{5'h08, 32'h0000_0100, 32'h0000_0100},   // R4 staging readback
      '{5'h0C, 32'h0000_00F2, 32'h0000_0002},   // R9 control bits 3:0 only
      '{5'h1C, 32'hFFFF_FFFF, VER},             // R2 version fixed
      '{5'h14, 32'h0000_0001, 32'h0000_0000},   // R9 raw not writable
      '{5'h00, 32'h5555_5555, 32'h0000_0000}    // R4 staged value waits for run
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic        rd_en = 1'b0;
   logic [4:0]  addr = '0;
   logic [31:0] wdata = '0;
   logic [31:0] rdata;
   logic        irq;

   int nchk = 0;
   int nfail = 0;

   always #10 clk = ~clk;

   sec_rtc #(.DATA_W(32), .ADDR_W(5), .DIV(DIV), .VERSION(VER)) dut_i (
      .clk_i   (clk),
      .rst_ni  (rst_n),
      .wr_en_i (wr_en),
      .rd_en_i (rd_en),
      .addr_i  (addr),
      .wdata_i (wdata),
      .rdata_o (rdata),
      .irq_o   (irq)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      nchk++;
      if (act !== exp) begin
         nfail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic bus_wr(input logic [4:0] a, input logic [31:0] d);
      addr = a; wdata = d; wr_en = 1'b1;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic bus_rd(input logic [4:0] a, output logic [31:0] d);
      addr = a; rd_en = 1'b1;
      #1 d = rdata;
      @(negedge clk);
      rd_en = 1'b0;
   endtask

   // wait for the count to leave old; ends on the negedge after the tick
   task automatic wait_change(input logic [31:0] old, output logic [31:0] nv);
      bit seen = 1'b0;
      addr = 5'h00; rd_en = 1'b0;
      for (int i = 0; i < 3 * DIV; i++) begin
         @(negedge clk);
         if (rdata != old) begin seen = 1'b1; break; end
      end
      nv = rdata;
      if (!seen) check("R3 tick timeout", rdata, old + 1);
   endtask

   task automatic wait_val(input logic [31:0] target);
      bit seen = 1'b0;
      addr = 5'h00; rd_en = 1'b0;
      for (int i = 0; i < 4 * DIV; i++) begin
         @(negedge clk);
         if (rdata == target) begin seen = 1'b1; break; end
      end
      if (!seen) check("R4 staged value never arrived", rdata, target);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      nfail++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
   end

   initial begin
      logic [31:0] v;
      logic [31:0] n;
      int cyc;

      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      bus_rd(5'h00, v); check("R1 count", v, 0);
      bus_rd(5'h04, v); check("R1 compare", v, 0);
      bus_rd(5'h08, v); check("R1 staging", v, 0);
      bus_rd(5'h0C, v); check("R1 control", v, 0);
      bus_rd(5'h10, v); check("R1 gated status", v, 0);
      bus_rd(5'h14, v); check("R1 raw status", v, 0);
      check("R1 irq", {31'b0, irq}, 0);
      bus_rd(5'h1C, v); check("R2 version", v, VER);

      // R2 R9 register table
      foreach (VECS[i]) begin
         bus_wr(VECS[i].a, VECS[i].w);
         bus_rd(VECS[i].a, v);
         check("R2/R9 table", v, VECS[i].e);
      end

      // R3 hold with run=0
      bus_wr(5'h0C, 32'h0);
      repeat (3 * DIV) @(negedge clk);
      bus_rd(5'h00, v); check("R3 hold while stopped", v, 0);

      // R4 R10 staged value taken on first run tick
      bus_wr(5'h0C, 32'h4);
      wait_change(32'h0, v); check("R10 staged beats increment", v, 32'h100);
      cyc = 0;
      addr = 5'h00;
      do begin @(negedge clk); cyc++; end while (rdata == v && cyc < 3 * DIV);
      check("R3 tick period", cyc, DIV);
      check("R3 increment", rdata, 32'h101);

      // R4 not applied before the tick
      bus_wr(5'h08, 32'h5000);
      bus_rd(5'h00, v); check("R4 no early load", v, 32'h101);
      wait_change(32'h101, v); check("R4 load at tick", v, 32'h5000);

      // R8 rollover with wrap=0
      bus_wr(5'h08, 32'hFFFF_FFFF);
      wait_change(32'h5000, v); check("R4 load all-ones", v, 32'hFFFF_FFFF);
      wait_change(v, n); check("R8 rollover", n, 0);

      // R5 R6 R7 match under mask
      bus_wr(5'h04, 32'h20);
      bus_wr(5'h08, 32'h1F);
      bus_wr(5'h0C, 32'h6);
      wait_val(32'h1F);
      wait_change(32'h1F, v); check("R5 count reaches compare", v, 32'h20);
      bus_rd(5'h14, v); check("R5 raw not yet", v, 0);
      wait_change(32'h20, v); check("R5 step past compare", v, 32'h21);
      bus_rd(5'h14, v); check("R5 raw set while masked", v, 1);
      bus_rd(5'h10, v); check("R6 gated status masked", v, 0);
      check("R6 irq masked", {31'b0, irq}, 0);
      bus_wr(5'h0C, 32'h7);
      check("R6 irq enable+mask", {31'b0, irq}, 0);
      bus_wr(5'h0C, 32'h5);
      check("R6 irq enabled", {31'b0, irq}, 1);
      bus_rd(5'h10, v); check("R6 gated status", v, 1);
      bus_rd(5'h18, v);
      bus_rd(5'h14, v); check("R7 ack clears raw", v, 0);
      check("R7 irq cleared", {31'b0, irq}, 0);

      // R8 wrap on match
      bus_wr(5'h04, 32'h40);
      bus_wr(5'h08, 32'h3F);
      bus_wr(5'h0C, 32'hD);
      wait_val(32'h3F);
      wait_change(32'h3F, v); check("R8 reach compare", v, 32'h40);
      wait_change(32'h40, v); check("R8 wrap to zero", v, 0);
      check("R6 irq after wrap match", {31'b0, irq}, 1);
      bus_rd(5'h18, v);

      // R7 ack collides with matching tick
      bus_wr(5'h0C, 32'h5);
      bus_wr(5'h04, 32'h60);
      bus_wr(5'h08, 32'h5F);
      wait_val(32'h5F);
      wait_change(32'h5F, v); check("R7 reach compare", v, 32'h60);
      repeat (DIV - 1) @(negedge clk);
      addr = 5'h18; rd_en = 1'b1;
      @(negedge clk);
      rd_en = 1'b0;
      bus_rd(5'h14, v); check("R7 set wins over ack", v, 1);
      bus_rd(5'h00, v); check("R7 count after collision", v, 32'h61);
      bus_rd(5'h18, v);
      bus_rd(5'h14, v); check("R7 later ack clears", v, 0);

      // R10 staged value beats wrap on a match tick
      bus_wr(5'h0C, 32'hD);
      bus_wr(5'h04, 32'h70);
      bus_wr(5'h08, 32'h6F);
      wait_val(32'h6F);
      wait_change(32'h6F, v); check("R10 reach compare", v, 32'h70);
      bus_wr(5'h08, 32'h900);
      wait_change(32'h70, v); check("R10 staged beats wrap", v, 32'h900);
      bus_rd(5'h14, v); check("R10 match still recorded", v, 1);

      $display("  TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
   end

endmodule